// File: doc/BRIEF.md
# Addressed Four-Bus Bridge with Hamming-Coded Links

The bridge takes request frames from an upstream message node over a valid/ready handshake and delivers each one to a single slave on one of four downstream two-wire serial buses. Each bus can carry up to four slaves. The bus and the slave come from fields of the frame identifier. The payload byte is protected with a 12-bit single-error-correcting Hamming code before it is shifted out. The bridge is the only clock source for the slaves: it drives the clock line of the selected bus from a programmable divider, and every clock line stays high while no exchange is in flight.

Once a frame has been accepted, the route stays locked to its bus and slave until the reply has gone back upstream. While the route is locked, further frames are held off. A write is answered with an acknowledge. A read is answered with the corrected data byte and a flag for a reply word that could not be corrected. If the slave does not begin a reply within a fixed number of clock periods, the route is released and a timeout response is returned.

Top module: `hamming_bus_bridge`

## Requirements
- R1: `req_ready` is high only when no exchange is in progress. It goes low on the cycle after a frame is accepted and returns high only after the response has been taken with `rsp_ready`. A frame presented while the route is locked is not taken and does not change the exchange in progress.
- R2: Identifier bits [3:2] select the bus. Only that bus's clock and data lines ever go low during the exchange. Every clock and data line is high whenever the bridge is idle.
- R3: The bridge sends each frame as an ordered bit series. First come identifier bit 1, then identifier bit 0, then the direction bit (1 = write, 0 = read). A write then adds the 12 codeword bits in position order 1 to 12, for 15 bits in total. A read sends only the 3 header bits. Each bit is driven while the clock is low and held through the high phase.
- R4: The codeword places data bits 0 to 7 at positions 3, 5, 6, 7, 9, 10, 11 and 12. It places parity at positions 1, 2, 4 and 8, chosen so that the XOR of the positions of all set bits is zero.
- R5: Each clock half period lasts `half_period`+1 system clock cycles, so the full bus clock period is 2*(`half_period`+1) cycles.
- R6: After the last request bit, the bridge releases the data line. A slave starts its reply by pulling the data line low at a rising clock edge. For a write, this start bit completes the exchange with response code 0 and data 0.
- R7: For a read, the start bit is followed by 12 reply bits in position order 1 to 12. The syndrome is the XOR of the positions of the set bits. A syndrome from 1 to 12 flips the bit at that position. The response carries code 1 and the extracted byte.
- R8: A read reply whose syndrome is 13, 14 or 15 sets `rsp_uncorr`. Otherwise `rsp_uncorr` is 0.
- R9: If no start bit is seen within TIMEOUT clock periods after the request bits, the route is released. The response then carries code 2 and data 0. A start bit seen in the last of those periods is still accepted.
- R10: `rsp_valid` stays high with stable code, data and flag until `rsp_ready`. `rsp_id` echoes the identifier of the accepted frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_period | input | HPW | Bus clock half period minus one, captured when a frame is accepted |
| req_valid | input | 1 | Upstream frame present |
| req_ready | output | 1 | Bridge can take a frame |
| req_id | input | 4 | Frame identifier: [3:2] bus, [1:0] slave |
| req_write | input | 1 | 1 = write, 0 = read |
| req_data | input | 8 | Write payload byte |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Upstream takes the response |
| rsp_id | output | 4 | Identifier of the answered frame |
| rsp_code | output | 2 | 0 write acknowledge, 1 read data, 2 timeout |
| rsp_data | output | 8 | Corrected read byte, else 0 |
| rsp_uncorr | output | 1 | Read reply could not be corrected |
| scl_o | output | 4 | Clock line of each bus |
| sda_o | output | 4 | Data line drive of each bus (1 = released) |
| sda_i | input | 4 | Data line level of each bus |

## Verification
The assertions check several properties on every cycle: that at most one bus is ever active, that all lines are released while idle, that the route lock is held while a response is pending, that a pending response stays stable, that a timeout carries zero data, and that the wait counter stays below its bound. The bench's scenarios are needed to show the bit order and codeword on the wire, the measured bus clock period, the exact number of clock periods spent in each phase, the correction of every single-bit and double-bit reply error, and the timeout limit on both sides of its last period.

// File: rtl/hamming_bus_bridge.sv
`timescale 1ns/1ps
module hamming_bus_bridge #(
  parameter int TIMEOUT = 16,
  parameter int HPW     = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [HPW-1:0] half_period,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [3:0]     req_id,
  input  logic           req_write,
  input  logic [7:0]     req_data,
  output logic           rsp_valid,
  input  logic           rsp_ready,
  output logic [3:0]     rsp_id,
  output logic [1:0]     rsp_code,
  output logic [7:0]     rsp_data,
  output logic           rsp_uncorr,
  output logic [3:0]     scl_o,
  output logic [3:0]     sda_o,
  input  logic [3:0]     sda_i
);
  localparam int TW = $clog2(TIMEOUT + 1);
  localparam logic [1:0] C_ACK = 2'd0, C_READ = 2'd1, C_TMO = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_TX, S_WAIT, S_RX, S_RESP} st_t;

  function automatic logic [11:0] ham_enc(input logic [7:0] d);
    logic [11:0] w;
    logic par;
    int k;
    w = '0;
    k = 0;
    for (int p = 1; p <= 12; p++)
      if ((p & (p - 1)) != 0) begin
        w[p-1] = d[k];
        k++;
      end
    for (int j = 0; j < 4; j++) begin
      par = 1'b0;
      for (int p = 1; p <= 12; p++)
        if (((p >> j) & 1) == 1 && (p & (p - 1)) != 0) par ^= w[p-1];
      w[(1 << j) - 1] = par;
    end
    return w;
  endfunction

  function automatic logic [8:0] ham_dec(input logic [11:0] wi);
    logic [11:0] w;
    logic [3:0]  s;
    logic [7:0]  d;
    int k;
    w = wi;
    s = '0;
    for (int p = 1; p <= 12; p++)
      if (w[p-1]) s ^= 4'(p);
    if (s != 4'd0 && s <= 4'd12) w[s - 4'd1] = ~w[s - 4'd1];
    d = '0;
    k = 0;
    for (int p = 1; p <= 12; p++)
      if ((p & (p - 1)) != 0) begin
        d[k] = w[p-1];
        k++;
      end
    return {(s > 4'd12), d};
  endfunction

  st_t            st;
  logic [3:0]     id_q;
  logic           wr_q;
  logic [HPW-1:0] hp_q, div;
  logic           scl, sda;
  logic [14:0]    txsr;
  logic [3:0]     txcnt, rxcnt;
  logic [TW-1:0]  tcnt;
  logic [10:0]    rxsr;
  logic [1:0]     code_q;
  logic [7:0]     data_q;
  logic           unc_q;

  wire        active  = (st == S_TX) || (st == S_WAIT) || (st == S_RX);
  wire        tick    = (div == hp_q);
  wire        sda_in  = sda_i[id_q[3:2]];
  wire [11:0] rx_word = {sda_in, rxsr};
  wire [8:0]  dec_w   = ham_dec(rx_word);

  assign req_ready  = (st == S_IDLE);
  assign rsp_valid  = (st == S_RESP);
  assign rsp_id     = id_q;
  assign rsp_code   = code_q;
  assign rsp_data   = data_q;
  assign rsp_uncorr = unc_q;

  for (genvar g = 0; g < 4; g++) begin : g_bus
    assign scl_o[g] = (active && id_q[3:2] == 2'(g)) ? scl : 1'b1;
    assign sda_o[g] = (active && id_q[3:2] == 2'(g)) ? sda : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;  id_q <= '0;  wr_q <= 1'b0;  hp_q <= '0;  div <= '0;
      scl <= 1'b1;   sda <= 1'b1; txsr <= '0;    txcnt <= '0; rxcnt <= '0;
      tcnt <= '0;    rxsr <= '0;  code_q <= C_ACK; data_q <= '0; unc_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          id_q  <= req_id;
          wr_q  <= req_write;
          hp_q  <= half_period;
          div   <= '0;
          scl   <= 1'b1;
          sda   <= 1'b1;
          txsr  <= {ham_enc(req_data), req_write, req_id[0], req_id[1]};
          txcnt <= req_write ? 4'd15 : 4'd3;
          tcnt  <= '0;
          st    <= S_TX;
        end
        S_TX, S_WAIT, S_RX: begin
          if (!tick) div <= div + 1'b1;
          else begin
            div <= '0;
            scl <= ~scl;
            if (scl) begin
              if (st == S_TX) begin
                if (txcnt == 4'd0) begin
                  sda <= 1'b1;
                  st  <= S_WAIT;
                end else begin
                  sda   <= txsr[0];
                  txsr  <= txsr >> 1;
                  txcnt <= txcnt - 1'b1;
                end
              end
            end else if (st == S_WAIT) begin
              if (!sda_in) begin
                if (wr_q) begin
                  code_q <= C_ACK; data_q <= '0; unc_q <= 1'b0; st <= S_RESP;
                end else begin
                  rxcnt <= 4'd12; st <= S_RX;
                end
              end else if (tcnt == TW'(TIMEOUT - 1)) begin
                code_q <= C_TMO; data_q <= '0; unc_q <= 1'b0; st <= S_RESP;
              end else tcnt <= tcnt + 1'b1;
            end else if (st == S_RX) begin
              rxsr  <= rx_word[11:1];
              rxcnt <= rxcnt - 1'b1;
              if (rxcnt == 4'd1) begin
                code_q <= C_READ; data_q <= dec_w[7:0]; unc_q <= dec_w[8]; st <= S_RESP;
              end
            end
          end
        end
        S_RESP: if (rsp_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_SINGLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~scl_o | ~sda_o)); // R2
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (&scl_o) && (&sda_o)); // R2
  AST_LOCK_WHILE_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready); // R1
  AST_ROUTE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready)) |-> $stable(rsp_id)); // R1
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_code) && $stable(rsp_data) && $stable(rsp_uncorr)); // R10
  AST_TIMEOUT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code == 2'd2) |-> (rsp_data == 8'd0) && !rsp_uncorr); // R9
  AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tcnt < TW'(TIMEOUT)); // R9
endmodule

// File: tb/hamming_bus_bridge_tb.sv
`timescale 1ns/1ps
module hamming_bus_bridge_tb;
  localparam int TO = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] half_period = 8'd1;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [3:0] req_id = '0;
  logic       req_write = 1'b0;
  logic [7:0] req_data = '0;
  logic       rsp_valid;
  logic       rsp_ready = 1'b0;
  logic [3:0] rsp_id;
  logic [1:0] rsp_code;
  logic [7:0] rsp_data;
  logic       rsp_uncorr;
  logic [3:0] scl_o, sda_o;
  logic [3:0] sda_i = 4'hF;

  int checks = 0;
  int errors = 0;
  int falls[4];

  always #4 clk = ~clk;

  hamming_bus_bridge #(.TIMEOUT(TO), .HPW(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .half_period(half_period),
    .req_valid(req_valid), .req_ready(req_ready), .req_id(req_id),
    .req_write(req_write), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_id(rsp_id),
    .rsp_code(rsp_code), .rsp_data(rsp_data), .rsp_uncorr(rsp_uncorr),
    .scl_o(scl_o), .sda_o(sda_o), .sda_i(sda_i));

  initial for (int g = 0; g < 4; g++) falls[g] = 0;
  for (genvar g = 0; g < 4; g++) begin : g_mon
    always @(negedge scl_o[g]) falls[g]++;
  end

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] syn(input logic [11:0] w);
    logic [3:0] s = '0;
    for (int p = 1; p <= 12; p++) if (w[p-1]) s ^= 4'(p);
    return s;
  endfunction

  function automatic bit is_par(input int p);
    return p == 1 || p == 2 || p == 4 || p == 8;
  endfunction

  function automatic logic [11:0] tb_enc(input logic [7:0] d);
    logic [11:0] w = '0;
    logic [3:0] s;
    int k = 0;
    for (int p = 1; p <= 12; p++) if (!is_par(p)) begin w[p-1] = d[k]; k++; end
    s = syn(w);
    for (int j = 0; j < 4; j++) if (s[j]) w[(1 << j) - 1] = 1'b1;
    return w;
  endfunction

  function automatic logic [8:0] tb_dec(input logic [11:0] wi);
    logic [11:0] w = wi;
    logic [3:0] s = syn(wi);
    logic [7:0] d = '0;
    int k = 0;
    if (s >= 1 && s <= 12) w[s-1] = ~w[s-1];
    for (int p = 1; p <= 12; p++) if (!is_par(p)) begin d[k] = w[p-1]; k++; end
    return {(s > 12), d};
  endfunction

  task automatic run(input logic [3:0] id, input logic wr, input logic [7:0] d, input int delay,
                     input logic [11:0] flip, input logic [7:0] hp, input bit intrude);
    int b, nb, expf;
    int f0[4];
    logic [14:0] got, exph, mask;
    logic [11:0] cw, rw;
    logic [8:0] er;
    time t0, t1;
    b  = int'(id[3:2]);
    nb = wr ? 15 : 3;
    cw = tb_enc(d);
    rw = cw ^ flip;
    @(negedge clk);
    half_period = hp; req_id = id; req_write = wr; req_data = d; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R1", "ready after accept", req_ready, 0);
    for (int g = 0; g < 4; g++) f0[g] = falls[g];
    if (intrude) begin
      req_id = ~id; req_write = ~wr; req_data = ~d; req_valid = 1'b1;
    end
    got = '0; t0 = 0; t1 = 0;
    for (int i = 0; i < nb; i++) begin
      @(posedge scl_o[b]);
      if (i == 0) t0 = $time;
      if (i == 1) t1 = $time;
      got[i] = sda_o[b];
    end
    if (delay >= 0) begin
      repeat (delay) @(negedge scl_o[b]);
      @(negedge scl_o[b]);
      sda_i[b] = 1'b0;
      @(posedge scl_o[b]);
      sda_i[b] = 1'b1;
      if (!wr)
        for (int i = 0; i < 12; i++) begin
          @(negedge scl_o[b]);
          sda_i[b] = rw[i];
          @(posedge scl_o[b]);
          sda_i[b] = 1'b1;
        end
    end
    while (rsp_valid !== 1'b1) @(negedge clk);
    exph = {cw, wr, id[0], id[1]};
    mask = wr ? 15'h7FFF : 15'h0007;
    check("R3", "header and codeword on wire", got & mask, exph & mask);
    check("R5", "bus clock period in ns", t1 - t0, 16 * (int'(hp) + 1));
    check("R1", "ready while response pending", req_ready, 0);
    check("R10", "response id", rsp_id, id);
    if (delay < 0) begin
      check("R9", "timeout code", rsp_code, 2);
      check("R9", "timeout data", rsp_data, 0);
    end else if (wr) begin
      check("R6", "write ack code", rsp_code, 0);
      check("R6", "write ack data", rsp_data, 0);
    end else begin
      er = tb_dec(rw);
      check("R7", "read code", rsp_code, 1);
      check("R7", "read data", rsp_data, er[7:0]);
      check("R8", "uncorrectable flag", rsp_uncorr, er[8]);
    end
    expf = (delay < 0) ? nb + TO : nb + delay + 1 + (wr ? 0 : 12);
    for (int g = 0; g < 4; g++)
      check("R2", "clock falls per bus", falls[g] - f0[g], (g == b) ? expf : 0);
    er = {rsp_uncorr, rsp_data};
    repeat (2) @(negedge clk);
    check("R10", "response held without ready", rsp_valid, 1);
    check("R10", "response stable", {rsp_uncorr, rsp_data}, er);
    rsp_ready = 1'b1; req_valid = 1'b0;
    @(negedge clk);
    rsp_ready = 1'b0;
    check("R1", "ready after response taken", req_ready, 1);
    check("R2", "all lines released when idle", {scl_o, sda_o}, 8'hFF);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog expired cycles=%0d expected below %0d", 190000, 190000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "reset ready", req_ready, 1);
    check("R10", "reset rsp_valid", rsp_valid, 0);
    check("R2", "reset lines high", {scl_o, sda_o}, 8'hFF);
    rst_n = 1'b1;
    for (int i = 0; i < 12; i++) check("R4", "encoder codeword check", syn(tb_enc(8'(i * 21))), 0);
    // R6 R3: writes to every bus and slave
    for (int id = 0; id < 16; id++) run(4'(id), 1'b1, 8'(id * 37 + 5), id % 3, 12'h0, 8'(id % 3), 1'b0);
    // R7: reads of every byte value
    for (int d = 0; d < 256; d++) run(4'(d), 1'b0, 8'(d), 0, 12'h0, 8'(d % 3), 1'b0);
    // R7: every single-bit reply error
    for (int p = 0; p < 12; p++) begin
      run(4'(p), 1'b0, 8'h00, 1, 12'(1 << p), 8'd0, 1'b0);
      run(4'(p + 3), 1'b0, 8'hFF, 0, 12'(1 << p), 8'd1, 1'b0);
      run(4'(p + 1), 1'b0, 8'h5A, 2, 12'(1 << p), 8'd0, 1'b0);
    end
    // R8: every double-bit reply error
    for (int p = 0; p < 12; p++)
      for (int q = p + 1; q < 12; q++)
        run(4'(p ^ q), 1'b0, 8'(p * 16 + q), 0, 12'((1 << p) | (1 << q)), 8'd0, 1'b0);
    // R9: timeout on each bus, and a reply in the last allowed period
    for (int b = 0; b < 4; b++) begin
      run(4'(b * 4 + 1), 1'b1, 8'hC3, -1, 12'h0, 8'd1, 1'b0);
      run(4'(b * 4 + 2), 1'b0, 8'h3C, -1, 12'h0, 8'd0, 1'b0);
      run(4'(b * 4 + 3), 1'b1, 8'h81, TO - 1, 12'h0, 8'd0, 1'b0);
      run(4'(b * 4), 1'b0, 8'h7E, TO - 1, 12'h0, 8'd1, 1'b0);
    end
    // R5: slower divider
    run(4'h9, 1'b1, 8'hA5, 0, 12'h0, 8'd3, 1'b0);
    run(4'h6, 1'b0, 8'h96, 1, 12'h0, 8'd3, 1'b0);
    // R1: frames presented while the route is locked are held off
    run(4'h5, 1'b1, 8'h12, 0, 12'h0, 8'd1, 1'b1);
    run(4'hE, 1'b0, 8'hE7, 2, 12'h0, 8'd0, 1'b1);
    run(4'h3, 1'b0, 8'h44, -1, 12'h0, 8'd0, 1'b1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule